// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Delivery Controller

This block is the wired-delivery back end of an interrupt controller. It serves a small number of harts. Each hart owns a 32-byte register window with three writable controls: a delivery enable, a force bit and a priority threshold. The window also has two read-only views of the best waiting interrupt for that hart. The source logic drives the per-source pending, enable and input-level vectors, the trigger mode of each source, and each source's target hart and priority. From these the block picks, for every hart, the most urgent eligible source. It drives one registered interrupt line per hart.

Software reads the claim register to take the selected interrupt. The read returns the same value as the top-interrupt register. It also produces one-cycle clear-pending and set-pending pulses back to the source logic. Those pulses let the source logic drop the pending bit, or keep it when a level-triggered source is still active. Source number 0 does not exist and is never selected. Bus decoding outside the hart windows is done elsewhere.

Top module: `hart_irq_deliver`

## Requirements
- R1: In each hart window, the delivery enable sits at offset 0x00, force at 0x04 and threshold at 0x08. Delivery enable and force store only write-data bit 0. The threshold stores the low PRIO_BITS bits. All three read back as written, and all reset to 0. A read returns data on `bus_rdata_o` one cycle after the request, with `bus_rvalid_o` high.
- R2: A source s (s ≥ 1) is a candidate for hart h only when all three of these hold: its pending bit is set, its enable bit is set, and its HART_W-bit target field equals h.
- R3: Among the candidates, the lowest effective priority value wins. When two candidates have equal priority, the lower source number wins.
- R4: A nonzero threshold T removes every candidate whose effective priority is ≥ T. A threshold of 0 removes nothing.
- R5: The top-interrupt register at offset 0x18 reads as the winning source number in bits 25:16 and its effective priority in bits 7:0, with every other bit 0. It reads as 0 when the hart has no candidate.
- R6: A source whose priority field is 0 is treated as having priority 1 everywhere: in the comparison, in the threshold test and in the reported value.
- R7: A read of the claim register at offset 0x1C returns the top-interrupt value. When that value is nonzero, the next cycle carries a one-cycle `clr_pend_o` pulse on the claimed source's bit only.
- R8: When a source is claimed, `set_pend_o` pulses on its bit in the same cycle as the clear pulse in two cases: its mode is level-high (code 2'b10) and its input is 1, or its mode is level-low (code 2'b11) and its input is 0. Any other mode code gives no set pulse.
- R9: A claim read that finds no candidate returns 0, produces no pulses and clears that hart's force bit.
- R10: `irq_o[h]` is high in the cycle after the domain enable, the hart's delivery enable and either force or a nonzero top value were all true. Otherwise it is low.
- R11: An access whose hart field (address bits 7:5) is NUM_HARTS or more, or whose offset is not one of the five registers, reads 0 and changes nothing. Writes to the top-interrupt or claim offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_en_i | input | 1 | Domain-wide interrupt enable |
| src_pend_i | input | NUM_SRC | Pending bit per source (bit 0 unused) |
| src_en_i | input | NUM_SRC | Enable bit per source |
| src_lvl_i | input | NUM_SRC | Current input level per source |
| src_mode_i | input | 2*NUM_SRC | Trigger mode per source: 2'b10 level-high, 2'b11 level-low, other codes not level |
| tgt_hart_i | input | NUM_SRC*HART_W | Target hart index per source |
| tgt_prio_i | input | NUM_SRC*PRIO_BITS | Priority per source |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address: bits 7:5 select the hart, bits 4:0 the offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| clr_pend_o | output | NUM_SRC | One-cycle clear-pending pulse from a claim |
| set_pend_o | output | NUM_SRC | One-cycle set-pending pulse from a claim |
| irq_o | output | NUM_HARTS | Registered interrupt line per hart |

## Verification
The selection is first tried with sets of candidates that differ in one way only: a disabled source, a source aimed at another hart, a tie on priority, a priority field of zero, and a threshold just above and at the best priority. Each set separates one eligibility or ordering rule from the rest. Claims are issued on edge, level-high and level-low sources with the input both active and inactive, which tells re-arming apart from plain clearing. A claim of an empty hart with force set shows the force-clear path. A long random phase then mixes source changes with accesses inside and outside the windows. It compares every read, every pulse and every interrupt line against a behavioural model each cycle.

// File: rtl/hid_pkg.sv
`timescale 1ns/1ps
package hid_pkg;
  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  localparam logic [1:0] MODE_LVL_HI = 2'b10;
  localparam logic [1:0] MODE_LVL_LO = 2'b11;

  localparam int TOP_ID_LSB = 16;
endpackage

// File: rtl/hid_best_pick.sv
`timescale 1ns/1ps
module hid_best_pick #(
  parameter int NUM_SRC   = 32,
  parameter int HART_W    = 3,
  parameter int PRIO_BITS = 3,
  parameter int HART_ID   = 0,
  localparam int ID_W     = $clog2(NUM_SRC),
  localparam int NODES    = 2*NUM_SRC - 1
) (
  input  logic [NUM_SRC-1:0]           src_pend_i,
  input  logic [NUM_SRC-1:0]           src_en_i,
  input  logic [NUM_SRC*HART_W-1:0]    tgt_hart_i,
  input  logic [NUM_SRC*PRIO_BITS-1:0] tgt_prio_i,
  input  logic [PRIO_BITS-1:0]         thr_i,
  output logic                         found_o,
  output logic [ID_W-1:0]              best_id_o,
  output logic [PRIO_BITS-1:0]         best_prio_o
);
  // Heap-numbered comparison tree: node n has children 2n+1 and 2n+2,
  // leaves sit at NUM_SRC-1+i so left-to-right order equals source order.
  logic [NODES-1:0]                nv;
  logic [NODES-1:0][PRIO_BITS-1:0] np;
  logic [NODES-1:0][ID_W-1:0]      nid;

  genvar k, n;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_leaf
      logic [PRIO_BITS-1:0] raw_p;
      logic [PRIO_BITS-1:0] eff_p;
      logic                 hmatch;
      assign raw_p  = tgt_prio_i[k*PRIO_BITS +: PRIO_BITS];
      assign eff_p  = (raw_p == '0) ? PRIO_BITS'(1) : raw_p;
      assign hmatch = (tgt_hart_i[k*HART_W +: HART_W] == HART_W'(HART_ID));
      assign nv[NUM_SRC-1+k]  = (k != 0) && src_pend_i[k] && src_en_i[k] && hmatch &&
                                ((thr_i == '0) || (eff_p < thr_i));
      assign np[NUM_SRC-1+k]  = eff_p;
      assign nid[NUM_SRC-1+k] = ID_W'(k);
    end

    for (n = 0; n < NUM_SRC-1; n++) begin : g_node
      logic take_left;
      assign take_left = nv[2*n+1] && (!nv[2*n+2] || (np[2*n+1] <= np[2*n+2]));
      assign nv[n]  = nv[2*n+1] | nv[2*n+2];
      assign np[n]  = take_left ? np[2*n+1]  : np[2*n+2];
      assign nid[n] = take_left ? nid[2*n+1] : nid[2*n+2];
    end
  endgenerate

  assign found_o     = nv[0];
  assign best_id_o   = nid[0];
  assign best_prio_o = np[0];
endmodule

// File: rtl/hid_hart_ctx.sv
`timescale 1ns/1ps
module hid_hart_ctx #(
  parameter int NUM_SRC   = 32,
  parameter int HART_W    = 3,
  parameter int PRIO_BITS = 3,
  parameter int HART_ID   = 0,
  localparam int ID_W     = $clog2(NUM_SRC)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dom_en_i,
  input  logic                         wr_deliv_i,
  input  logic                         wr_force_i,
  input  logic                         wr_thr_i,
  input  logic                         wbit_i,
  input  logic [PRIO_BITS-1:0]         wthr_i,
  input  logic                         claim_i,
  input  logic [NUM_SRC-1:0]           src_pend_i,
  input  logic [NUM_SRC-1:0]           src_en_i,
  input  logic [NUM_SRC*HART_W-1:0]    tgt_hart_i,
  input  logic [NUM_SRC*PRIO_BITS-1:0] tgt_prio_i,
  output logic                         deliv_o,
  output logic                         force_o,
  output logic [PRIO_BITS-1:0]         thr_o,
  output logic [31:0]                  top_o,
  output logic                         irq_o
);
  logic                 deliv_q, force_q, irq_q;
  logic [PRIO_BITS-1:0] thr_q;
  logic                 found;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_BITS-1:0] best_prio;

  hid_best_pick #(
    .NUM_SRC(NUM_SRC), .HART_W(HART_W), .PRIO_BITS(PRIO_BITS), .HART_ID(HART_ID)
  ) u_pick (
    .src_pend_i (src_pend_i),
    .src_en_i   (src_en_i),
    .tgt_hart_i (tgt_hart_i),
    .tgt_prio_i (tgt_prio_i),
    .thr_i      (thr_q),
    .found_o    (found),
    .best_id_o  (best_id),
    .best_prio_o(best_prio)
  );

  always_comb begin
    top_o = '0;
    if (found) top_o = {6'd0, 10'(best_id), 8'd0, 8'(best_prio)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_deliv_i) deliv_q <= wbit_i;
      if (wr_force_i) force_q <= wbit_i;
      else if (claim_i && !found) force_q <= 1'b0;
      if (wr_thr_i) thr_q <= wthr_i;
      irq_q <= dom_en_i && deliv_q && (force_q || found);
    end
  end

  assign deliv_o = deliv_q;
  assign force_o = force_q;
  assign thr_o   = thr_q;
  assign irq_o   = irq_q;

  // R4
  thr_respected_chk: assert property (@(posedge clk) disable iff (rst)
    (found && thr_q != '0) |-> (best_prio < thr_q));
  // R9
  empty_claim_force_chk: assert property (@(posedge clk) disable iff (rst)
    (claim_i && !found) |=> !force_q);
  // R10
  dom_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dom_en_i |=> !irq_q);
endmodule

// File: rtl/hart_irq_deliver.sv
`timescale 1ns/1ps
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int NUM_SRC   = 32,
  parameter int HART_W    = 3,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  localparam int ID_W     = $clog2(NUM_SRC),
  localparam int SEL_W    = ADDR_W - 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dom_en_i,
  input  logic [NUM_SRC-1:0]           src_pend_i,
  input  logic [NUM_SRC-1:0]           src_en_i,
  input  logic [NUM_SRC-1:0]           src_lvl_i,
  input  logic [2*NUM_SRC-1:0]         src_mode_i,
  input  logic [NUM_SRC*HART_W-1:0]    tgt_hart_i,
  input  logic [NUM_SRC*PRIO_BITS-1:0] tgt_prio_i,
  input  logic                         bus_req_i,
  input  logic                         bus_we_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [31:0]                  bus_wdata_i,
  output logic [31:0]                  bus_rdata_o,
  output logic                         bus_rvalid_o,
  output logic [NUM_SRC-1:0]           clr_pend_o,
  output logic [NUM_SRC-1:0]           set_pend_o,
  output logic [NUM_HARTS-1:0]         irq_o
);
  logic [SEL_W-1:0] hart_sel;
  logic [4:0]       off;
  logic             hit, rd_req, wr_req, claim_n;
  logic             wdata_unused;

  assign hart_sel     = bus_addr_i[ADDR_W-1:5];
  assign off          = bus_addr_i[4:0];
  assign hit          = int'(hart_sel) < NUM_HARTS;
  assign rd_req       = bus_req_i && !bus_we_i;
  assign wr_req       = bus_req_i && bus_we_i && hit;
  assign claim_n      = rd_req && hit && (off == OFF_CLAIM);
  assign wdata_unused = ^bus_wdata_i[31:PRIO_BITS];

  logic [NUM_HARTS-1:0]                deliv_all, force_all;
  logic [NUM_HARTS-1:0][PRIO_BITS-1:0] thr_all;
  logic [NUM_HARTS-1:0][31:0]          top_all;

  genvar h;
  generate
    for (h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic mine;
      assign mine = (hart_sel == SEL_W'(h));
      hid_hart_ctx #(
        .NUM_SRC(NUM_SRC), .HART_W(HART_W), .PRIO_BITS(PRIO_BITS), .HART_ID(h)
      ) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .dom_en_i  (dom_en_i),
        .wr_deliv_i(wr_req && mine && off == OFF_DELIV),
        .wr_force_i(wr_req && mine && off == OFF_FORCE),
        .wr_thr_i  (wr_req && mine && off == OFF_THR),
        .wbit_i    (bus_wdata_i[0]),
        .wthr_i    (bus_wdata_i[PRIO_BITS-1:0]),
        .claim_i   (claim_n && mine),
        .src_pend_i(src_pend_i),
        .src_en_i  (src_en_i),
        .tgt_hart_i(tgt_hart_i),
        .tgt_prio_i(tgt_prio_i),
        .deliv_o   (deliv_all[h]),
        .force_o   (force_all[h]),
        .thr_o     (thr_all[h]),
        .top_o     (top_all[h]),
        .irq_o     (irq_o[h])
      );
    end
  endgenerate

  // Window selection for the addressed hart
  logic                 deliv_s, force_s;
  logic [PRIO_BITS-1:0] thr_s;
  logic [31:0]          top_s;
  always_comb begin
    deliv_s = 1'b0;
    force_s = 1'b0;
    thr_s   = '0;
    top_s   = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (hart_sel == SEL_W'(i)) begin
        deliv_s = deliv_all[i];
        force_s = force_all[i];
        thr_s   = thr_all[i];
        top_s   = top_all[i];
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_DELIV: rd_mux = {31'd0, deliv_s};
        OFF_FORCE: rd_mux = {31'd0, force_s};
        OFF_THR:   rd_mux = 32'(thr_s);
        OFF_TOP,
        OFF_CLAIM: rd_mux = top_s;
        default:   rd_mux = '0;
      endcase
    end
  end

  // Claim side effects toward the source logic
  logic [ID_W-1:0]    cid;
  logic [1:0]         cmode;
  logic [NUM_SRC-1:0] clr_n, set_n;
  assign cid   = top_s[TOP_ID_LSB +: ID_W];
  assign cmode = src_mode_i[{cid, 1'b0} +: 2];
  always_comb begin
    clr_n = '0;
    set_n = '0;
    if (claim_n && top_s != '0) begin
      clr_n = NUM_SRC'(1) << cid;
      if ((cmode == MODE_LVL_HI && src_lvl_i[cid]) ||
          (cmode == MODE_LVL_LO && !src_lvl_i[cid]))
        set_n = NUM_SRC'(1) << cid;
    end
  end

  logic [31:0]        rdata_q;
  logic               rvalid_q;
  logic [NUM_SRC-1:0] clr_q, set_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= '0;
      set_q    <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_mux : '0;
      clr_q    <= clr_n;
      set_q    <= set_n;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign clr_pend_o   = clr_q;
  assign set_pend_o   = set_q;

  // R7
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_pend_o));
  // R8
  set_within_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (set_pend_o & ~clr_pend_o) == '0);
  // R2
  no_src_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_pend_o[0]);
  // R7
  pulse_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pend_o != '0) |-> bus_rvalid_o);
endmodule

// File: tb/tb_hart_irq_deliver.sv
`timescale 1ns/1ps
module tb_hart_irq_deliver;
  localparam int NH = 4;
  localparam int NS = 32;
  localparam int HW = 3;
  localparam int PB = 3;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              dom_en;
  logic [NS-1:0]     pend, en, lvl;
  logic [2*NS-1:0]   mode;
  logic [NS*HW-1:0]  thart;
  logic [NS*PB-1:0]  tprio;
  logic              breq, bwe;
  logic [AW-1:0]     baddr;
  logic [31:0]       bwd;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [NS-1:0]     clr, set;
  logic [NH-1:0]     irq;

  hart_irq_deliver #(.NUM_HARTS(NH), .NUM_SRC(NS), .HART_W(HW), .PRIO_BITS(PB), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .dom_en_i(dom_en),
    .src_pend_i(pend), .src_en_i(en), .src_lvl_i(lvl), .src_mode_i(mode),
    .tgt_hart_i(thart), .tgt_prio_i(tprio),
    .bus_req_i(breq), .bus_we_i(bwe), .bus_addr_i(baddr), .bus_wdata_i(bwd),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .clr_pend_o(clr), .set_pend_o(set), .irq_o(irq)
  );

  // Behavioural reference state
  bit m_del [NH];
  bit m_frc [NH];
  int m_thr [NH];
  int checks = 0;
  int errors = 0;

  function automatic int effp(int s);
    int p;
    p = int'(tprio[s*PB +: PB]);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [31:0] m_top(int h);
    int best;
    int bp;
    best = -1;
    bp = 1000;
    for (int s = 1; s < NS; s++) begin
      int p;
      p = effp(s);
      if (pend[s] && en[s] && int'(thart[s*HW +: HW]) == h &&
          (m_thr[h] == 0 || p < m_thr[h]) && p < bp) begin
        bp = p;
        best = s;
      end
    end
    if (best < 0) return 32'd0;
    return (32'(best) << 16) | 32'(bp);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle; called and returns at a falling edge.
  task automatic cyc(bit req, bit we, logic [7:0] a, logic [31:0] d, string tag);
    logic [NH-1:0] eirq;
    logic [31:0]   erd;
    logic [NS-1:0] eclr, eset;
    bit            erv;
    int            h, off;
    breq = req; bwe = we; baddr = a; bwd = d;
    for (int i = 0; i < NH; i++)
      eirq[i] = dom_en && m_del[i] && (m_frc[i] || m_top(i) != 0);
    erd = 0; erv = req && !we; eclr = 0; eset = 0;
    h = int'(a[7:5]); off = int'(a[4:0]);
    if (req && h < NH) begin
      if (!we) begin
        case (off)
          'h00: erd = 32'(m_del[h]);
          'h04: erd = 32'(m_frc[h]);
          'h08: erd = 32'(m_thr[h]);
          'h18: erd = m_top(h);
          'h1C: begin
            int s;
            erd = m_top(h);
            if (erd == 0) m_frc[h] = 1'b0;
            else begin
              s = int'(erd[25:16]);
              eclr[s] = 1'b1;
              if ((mode[2*s +: 2] == 2'b10 && lvl[s]) || (mode[2*s +: 2] == 2'b11 && !lvl[s]))
                eset[s] = 1'b1;
            end
          end
          default: erd = 0;
        endcase
      end else begin
        case (off)
          'h00: m_del[h] = d[0];
          'h04: m_frc[h] = d[0];
          'h08: m_thr[h] = int'(d[PB-1:0]);
          default: ;
        endcase
      end
    end
    @(posedge clk); #1;
    chk("R10 irq", 32'(irq), 32'(eirq));
    chk({tag, " rvalid"}, 32'(rvalid), 32'(erv));
    if (erv) chk({tag, " rdata"}, rdata, erd);
    chk("R7 clr_pend", clr, eclr);
    chk("R8 set_pend", set, eset);
    pend = (pend & ~eclr) | eset;
    breq = 1'b0; bwe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cyc(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic src(int s, bit p, bit e, int h, int pr, logic [1:0] md, bit l);
    pend[s] = p; en[s] = e; lvl[s] = l;
    thart[s*HW +: HW] = HW'(h);
    tprio[s*PB +: PB] = PB'(pr);
    mode[2*s +: 2] = md;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    dom_en = 1'b1; pend = '0; en = '0; lvl = '0; mode = '0; thart = '0; tprio = '0;
    breq = 0; bwe = 0; baddr = '0; bwd = '0;
    for (int i = 0; i < NH; i++) begin m_del[i] = 0; m_frc[i] = 0; m_thr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // Reset state (R1, R5)
    rd(8'h00, "R1 reset deliv"); rd(8'h04, "R1 reset force"); rd(8'h08, "R1 reset thr");
    rd(8'h18, "R5 reset top");

    // Register masking (R1)
    wr(8'h00, 32'hFFFF_FFFF, "R1"); rd(8'h00, "R1 deliv bit0");
    wr(8'h08, 32'h0000_00FD, "R1"); rd(8'h08, "R1 thr masked");
    wr(8'h08, 32'h0, "R1"); wr(8'h20, 32'h2, "R1"); rd(8'h20, "R1 deliv bit0 only");

    // Eligibility (R2)
    src(3, 1, 1, 0, 5, 2'b00, 0);
    src(7, 1, 0, 0, 2, 2'b00, 0);
    src(9, 1, 1, 1, 1, 2'b00, 0);
    src(14, 0, 1, 0, 1, 2'b00, 0);
    src(15, 1, 1, 6, 1, 2'b00, 0);
    rd(8'h18, "R2 top hart0"); rd(8'h38, "R2 top hart1"); rd(8'h58, "R2 top hart2");
    cyc(0, 0, 8'h0, 0, "R10");

    // Ordering and ties (R3)
    src(12, 1, 1, 0, 2, 2'b11, 0);
    src(5, 1, 1, 0, 2, 2'b10, 1);
    rd(8'h18, "R3 tie lowest id");

    // Threshold (R4)
    wr(8'h08, 32'd2, "R4"); rd(8'h18, "R4 thr excludes equal");
    wr(8'h08, 32'd3, "R4"); rd(8'h18, "R4 thr passes lower");
    wr(8'h08, 32'd0, "R4"); rd(8'h18, "R4 zero thr");

    // Priority zero treated as one (R6)
    src(20, 1, 1, 0, 0, 2'b00, 0);
    rd(8'h18, "R6 prio zero");
    wr(8'h08, 32'd1, "R6"); rd(8'h18, "R6 thr1 blocks prio0");
    wr(8'h08, 32'd0, "R6");

    // Claims and re-arm (R7, R8)
    rd(8'h1C, "R7 claim edge src");
    rd(8'h18, "R7 after claim");
    rd(8'h1C, "R8 claim level-high active");
    rd(8'h18, "R8 still pending");
    lvl[5] = 1'b0;
    rd(8'h1C, "R8 claim level-high idle");
    rd(8'h1C, "R8 claim level-low active");
    lvl[12] = 1'b1;
    rd(8'h1C, "R8 claim level-low idle");
    rd(8'h1C, "R7 claim remaining");

    // Force and empty claim (R9, R10)
    wr(8'h24, 32'd1, "R10"); wr(8'h20, 32'd0, "R10");
    cyc(0, 0, 8'h0, 0, "R10"); wr(8'h20, 32'd1, "R10");
    cyc(0, 0, 8'h0, 0, "R10");
    rd(8'h3C, "R9 claim nonempty keeps force"); rd(8'h24, "R9 force kept");
    rd(8'h3C, "R9 empty claim"); rd(8'h24, "R9 force cleared");
    cyc(0, 0, 8'h0, 0, "R10");

    // Domain enable (R10)
    src(4, 1, 1, 2, 3, 2'b00, 0); wr(8'h40, 32'd1, "R10");
    cyc(0, 0, 8'h0, 0, "R10");
    dom_en = 1'b0; cyc(0, 0, 8'h0, 0, "R10"); cyc(0, 0, 8'h0, 0, "R10");
    dom_en = 1'b1; cyc(0, 0, 8'h0, 0, "R10");

    // Unmapped accesses (R11)
    wr(8'h88, 32'd1, "R11"); rd(8'h88, "R11 out-of-range hart");
    wr(8'hE4, 32'd1, "R11"); rd(8'hE4, "R11 out-of-range force");
    wr(8'h58, 32'hFFFF, "R11"); rd(8'h58, "R11 top write ignored");
    wr(8'h5C, 32'hFFFF, "R11"); rd(8'h40, "R11 claim write ignored");
    rd(8'h0C, "R11 hole offset"); wr(8'h10, 32'hFF, "R11"); rd(8'h10, "R11 hole offset 2");

    // Random mix (R3)
    for (int it = 0; it < 1500; it++) begin
      int s;
      int pick;
      logic [4:0] offs [6];
      offs[0] = 5'h00; offs[1] = 5'h04; offs[2] = 5'h08;
      offs[3] = 5'h18; offs[4] = 5'h1C; offs[5] = 5'h0C;
      s = 1 + int'($urandom % (NS-1));
      if ($urandom % 2 == 0)
        src(s, 1'($urandom), 1'($urandom), int'($urandom % 5), int'($urandom % 8),
            2'($urandom), 1'($urandom));
      if ($urandom % 40 == 0) dom_en = ~dom_en;
      pick = int'($urandom % 6);
      if ($urandom % 3 == 0) cyc(0, 0, 8'h0, 0, "R3");
      else cyc(1'b1, ($urandom % 3 == 0), {3'($urandom % 6), offs[pick]}, $urandom, "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule